// File: doc/BRIEF.md
# Guarded Clock-Generator Control Registers

This block holds the settings that steer an external clock generator: a run bit, a bypass-release bit and a multiplier code. Software never writes these settings directly. Writes land in staging copies, and the staging copies move into the working copies only when a fixed two-word unlock pattern arrives at a dedicated key address. A stray write or a runaway loop therefore cannot reprogram the clock tree by accident.

The working copies drive the generator's run and release pins and its multiplier code. A status word reports the working state and the generator's lock input, so software can wait for lock before it releases the bypass. A CPU clock divider code sits beside the guarded registers. It takes effect at once, and its ratio output is the code plus one. Each step of a clock change (drop release, stop, set multiplier, start, release) is meant to have its own unlock pattern.

Top module: `clkgen_guard_regs`

## Requirements
- R1: After reset, the run, release and multiplier outputs are 0, every readable word reads 0 (apart from the lock input at status bit 26), and the CPU divider ratio output is 1.
- R2: A write to word 0 (bit 0 run, bit 1 release) or to word 1 (bits [MULT_W-1:0] multiplier minus one) changes only the staging copy. The staging copy reads back at once, and the generator outputs keep their values.
- R3: A write of 0xAA to the key word 2 followed by a write of 0x55 to the same word copies the staging state into the working state. Only the low 8 bits of the key write are compared. The outputs show the new state in the cycle after the 0x55 write.
- R4: A first key word other than 0xAA, a second key word other than 0x55, or any read or any write to another word between the two key words aborts the pattern and commits nothing. A lone 0x55 commits nothing.
- R5: One pattern commits exactly once. Staging writes made after a commit, and a repeated 0x55, leave the working state unchanged.
- R6: A commit copies the staged multiplier only if the working run bit was 0 before that commit. Otherwise the working multiplier keeps its value.
- R7: The working release bit becomes 1 only when the same commit also sets the run bit. A commit that stages release without run leaves release at 0.
- R8: Status word 3 reads the lock input at bit 26, the working run bit at bit 24, the working release bit at bit 25 and the working multiplier at bits [MULT_W-1:0].
- R9: Word 4 holds an 8-bit CPU divider code that is written directly, with no key. It reads back, and the ratio output equals the code plus one from the next cycle on.
- R10: Idle cycles with no bus access between the two key words do not abort the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (counts as a bus access) |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| pll_lock | input | 1 | Lock indication from the generator |
| pll_run | output | 1 | Working run bit |
| pll_release | output | 1 | Working bypass-release bit |
| pll_mult_m1 | output | MULT_W (15) | Working multiplier minus one |
| cpu_div_ratio | output | CDIV_W+1 (9) | CPU divide ratio (code plus one) |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle, that reset is held at the start of a run, and that the lock input rises only while the run output is 1. The stimulus drives one bus operation at a time on the falling edge. The lock driver in the bench raises the lock input a fixed delay after run goes high and clears it as soon as run drops. The reference model in the bench treats every strobe as a separate access, so the aborted patterns it plays (wrong first word, wrong second word, an intervening read, an intervening staging write) never depend on two strobes being combined.

// File: rtl/clkgen_guard_pkg.sv
package clkgen_guard_pkg;
   // word map
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_CFG  = 1;
   localparam int unsigned REG_KEY  = 2;
   localparam int unsigned REG_STAT = 3;
   localparam int unsigned REG_CDIV = 4;
   // bit positions
   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_REL_BIT = 1;
   localparam int unsigned STAT_RUN_BIT = 24;
   localparam int unsigned STAT_REL_BIT = 25;

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_ARMED = 1'b1
   } seq_state_t;
endpackage

// File: rtl/cgg_unlock_seq.sv
module cgg_unlock_seq
   import clkgen_guard_pkg::*;
#(
   parameter int unsigned     KEY_W      = 8,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 'hAA,
   parameter logic [KEY_W-1:0] KEY_SECOND = 'h55,
   parameter bit              STRICT     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic             other_acc,
   input  logic [KEY_W-1:0] key,
   output logic             commit
);
   seq_state_t state_q, state_d;
   logic       idle_drop;

   generate
      if (STRICT) begin : g_strict
         // any cycle without a key write breaks the pattern
         assign idle_drop = 1'b1;
      end else begin : g_loose
         assign idle_drop = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      commit  = 1'b0;
      case (state_q)
         SEQ_IDLE: begin
            if (key_wr && key == KEY_FIRST) state_d = SEQ_ARMED;
         end
         SEQ_ARMED: begin
            if (key_wr) begin
               commit  = (key == KEY_SECOND);
               state_d = SEQ_IDLE;
            end else if (other_acc || idle_drop) begin
               state_d = SEQ_IDLE;
            end
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   // R5: a commit consumes the pattern
   a_r5_commit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> state_q == SEQ_IDLE);
   // R4: a foreign access while armed returns to idle
   a_r4_access_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_ARMED && other_acc && !key_wr) |=> state_q == SEQ_IDLE);
   // R3: arming needs a key write
   a_r3_arm_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_IDLE && !key_wr) |=> state_q == SEQ_IDLE);
endmodule

// File: rtl/cgg_commit.sv
module cgg_commit #(
   parameter int unsigned MULT_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              st_run,
   input  logic              st_rel,
   input  logic [MULT_W-1:0] st_mult,
   output logic              act_run,
   output logic              act_rel,
   output logic [MULT_W-1:0] act_mult
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_run  <= 1'b0;
         act_rel  <= 1'b0;
         act_mult <= '0;
      end else if (commit) begin
         act_run <= st_run;
         act_rel <= st_rel & st_run;
         if (!act_run) act_mult <= st_mult;
      end
   end

   // R7: release never stands without run
   a_r7_rel_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      act_rel |-> act_run);
   // R6: multiplier frozen across a commit made while running
   a_r6_mult_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && act_run) |=> $stable(act_mult));
   // R5: working state moves only on a commit
   a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(act_run) && $stable(act_rel) && $stable(act_mult)));
endmodule

// File: rtl/clkgen_guard_regs.sv
module clkgen_guard_regs
   import clkgen_guard_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned MULT_W   = 15,
   parameter int unsigned CDIV_W   = 8,
   parameter int unsigned KEY_W    = 8,
   parameter int unsigned LOCK_BIT = 26,
   parameter bit          STRICT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pll_lock,
   output logic              pll_run,
   output logic              pll_release,
   output logic [MULT_W-1:0] pll_mult_m1,
   output logic [CDIV_W:0]   cpu_div_ratio
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
   localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(REG_KEY);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
   localparam logic [ADDR_W-1:0] A_CDIV = ADDR_W'(REG_CDIV);

   // elaboration checks
   if (MULT_W > STAT_RUN_BIT) begin : g_bad_mult
      $error("MULT_W overlaps the status flags");
   end
   if (LOCK_BIT >= DATA_W || LOCK_BIT <= STAT_REL_BIT) begin : g_bad_lock
      $error("LOCK_BIT out of range");
   end
   if (CDIV_W >= DATA_W || KEY_W > DATA_W) begin : g_bad_width
      $error("field wider than the data bus");
   end
   if ((1 << ADDR_W) <= REG_CDIV) begin : g_bad_addr
      $error("ADDR_W too small for the word map");
   end

   logic              st_run, st_rel;
   logic [MULT_W-1:0] st_mult;
   logic [CDIV_W-1:0] cdiv_q;
   logic              key_wr, other_acc, commit;

   assign key_wr    = bus_wr && bus_addr == A_KEY;
   assign other_acc = (bus_wr || bus_rd) && !key_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_run  <= 1'b0;
         st_rel  <= 1'b0;
         st_mult <= '0;
         cdiv_q  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_CTRL: begin
               st_run <= bus_wdata[CTRL_RUN_BIT];
               st_rel <= bus_wdata[CTRL_REL_BIT];
            end
            A_CFG:   st_mult <= bus_wdata[MULT_W-1:0];
            A_CDIV:  cdiv_q  <= bus_wdata[CDIV_W-1:0];
            default: ;
         endcase
      end
   end

   cgg_unlock_seq #(
      .KEY_W      (KEY_W),
      .KEY_FIRST  (KEY_W'('hAA)),
      .KEY_SECOND (KEY_W'('h55)),
      .STRICT     (STRICT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_wr    (key_wr),
      .other_acc (other_acc),
      .key       (bus_wdata[KEY_W-1:0]),
      .commit    (commit)
   );

   cgg_commit #(
      .MULT_W (MULT_W)
   ) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .st_run   (st_run),
      .st_rel   (st_rel),
      .st_mult  (st_mult),
      .act_run  (pll_run),
      .act_rel  (pll_release),
      .act_mult (pll_mult_m1)
   );

   assign cpu_div_ratio = {1'b0, cdiv_q} + (CDIV_W+1)'(1);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[CTRL_RUN_BIT] = st_run;
            bus_rdata[CTRL_REL_BIT] = st_rel;
         end
         A_CFG:  bus_rdata[MULT_W-1:0] = st_mult;
         A_STAT: begin
            bus_rdata[MULT_W-1:0]   = pll_mult_m1;
            bus_rdata[STAT_RUN_BIT] = pll_run;
            bus_rdata[STAT_REL_BIT] = pll_release;
            bus_rdata[LOCK_BIT]     = pll_lock;
         end
         A_CDIV:  bus_rdata[CDIV_W-1:0] = cdiv_q;
         default: ;
      endcase
   end

   // R2: a staging write alone never moves the outputs
   a_r2_stage_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != A_KEY) |=> ($stable(pll_run) && $stable(pll_release)));
   // R9: divider follows a direct write on the next cycle
   a_r9_div_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CDIV)
      |=> cpu_div_ratio == {1'b0, $past(bus_wdata[CDIV_W-1:0])} + (CDIV_W+1)'(1));
endmodule

// File: tb/clkgen_guard_regs_bench.sv
module clkgen_guard_regs_bench;
   localparam int MULT_W = 15;
   localparam int CDIV_W = 8;
   localparam int LOCK_DLY = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pll_lock = 1'b0;
   logic        pll_run, pll_release;
   logic [MULT_W-1:0] pll_mult_m1;
   logic [CDIV_W:0]   cpu_div_ratio;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   clkgen_guard_regs u_clkgen_guard_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pll_lock(pll_lock), .pll_run(pll_run), .pll_release(pll_release),
      .pll_mult_m1(pll_mult_m1), .cpu_div_ratio(cpu_div_ratio)
   );

   // behavioural lock source
   int lk_cnt = 0;
   always @(posedge clk) begin
      if (!rst_n || !pll_run) begin
         lk_cnt <= 0;
         pll_lock <= 1'b0;
      end else if (lk_cnt == LOCK_DLY) pll_lock <= 1'b1;
      else lk_cnt <= lk_cnt + 1;
   end

   // reference model
   int m_run, m_rel, m_mult, m_srun, m_srel, m_smult, m_cdiv, m_armed;
   bit m_key, m_oth;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_rel = 0; m_mult = 0; m_srun = 0; m_srel = 0;
         m_smult = 0; m_cdiv = 0; m_armed = 0;
      end else begin
         m_key = bus_wr && bus_addr == 3'd2;
         m_oth = (bus_wr || bus_rd) && !m_key;
         if (m_armed != 0) begin
            if (m_key) begin
               if (bus_wdata[7:0] == 8'h55) begin
                  if (m_run == 0) m_mult = m_smult;
                  m_rel = (m_srel != 0 && m_srun != 0) ? 1 : 0;
                  m_run = m_srun;
               end
               m_armed = 0;
            end else if (m_oth) m_armed = 0;
         end else if (m_key && bus_wdata[7:0] == 8'hAA) m_armed = 1;
         if (bus_wr && bus_addr == 3'd0) begin
            m_srun = int'(bus_wdata[0]);
            m_srel = int'(bus_wdata[1]);
         end
         if (bus_wr && bus_addr == 3'd1) m_smult = int'(bus_wdata[MULT_W-1:0]);
         if (bus_wr && bus_addr == 3'd4) m_cdiv = int'(bus_wdata[CDIV_W-1:0]);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // every-cycle comparison against the model (R3 R5 R6 R7 R9)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 model run", 32'(pll_run), 32'(m_run));
         chk("R7 model release", 32'(pll_release), 32'(m_rel));
         chk("R6 model mult", 32'(pll_mult_m1), 32'(m_mult));
         chk("R9 model ratio", 32'(cpu_div_ratio), 32'(m_cdiv + 1));
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = 3'(a); bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic feed();
      wr(2, 32'hAA);
      wr(2, 32'h55);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 run", 32'(pll_run), 0);
      chk("R1 release", 32'(pll_release), 0);
      chk("R1 mult", 32'(pll_mult_m1), 0);
      chk("R1 ratio", 32'(cpu_div_ratio), 1);
      rd(0, v); chk("R1 ctrl read", v, 0);
      rd(1, v); chk("R1 cfg read", v, 0);
      rd(3, v); chk("R1 stat read", v, 0);

      // R2 staging only
      wr(0, 32'h3);
      wr(1, 32'h13);
      chk("R2 run held", 32'(pll_run), 0);
      chk("R2 mult held", 32'(pll_mult_m1), 0);
      rd(0, v); chk("R2 ctrl readback", v, 32'h3);
      rd(1, v); chk("R2 cfg readback", v, 32'h13);

      // R7 release without run; R3 commit of the multiplier
      wr(0, 32'h2);
      feed();
      chk("R7 release blocked", 32'(pll_release), 0);
      chk("R3 mult committed", 32'(pll_mult_m1), 32'h13);
      chk("R3 run stays 0", 32'(pll_run), 0);

      // R4 aborted patterns
      wr(0, 32'h1);
      wr(2, 32'h12); wr(2, 32'h55);
      chk("R4 bad first word", 32'(pll_run), 0);
      wr(2, 32'hAA); rd(0, v); wr(2, 32'h55);
      chk("R4 read between", 32'(pll_run), 0);
      wr(2, 32'hAA); wr(1, 32'h13); wr(2, 32'h55);
      chk("R4 write between", 32'(pll_run), 0);
      wr(2, 32'hAA); wr(2, 32'hAB);
      chk("R4 bad second word", 32'(pll_run), 0);
      wr(2, 32'h55);
      chk("R4 lone second word", 32'(pll_run), 0);

      // R10 idle cycles between key words, upper key bits ignored (R3)
      wr(2, 32'hFFFF_FFAA);
      repeat (5) @(negedge clk);
      wr(2, 32'h1234_5655);
      chk("R10 idle gap commits", 32'(pll_run), 1);

      // R8 status word and lock polling
      rd(3, v);
      chk("R8 lock low right after run", 32'(v[26]), 0);
      chk("R8 run flag", 32'(v[24]), 1);
      chk("R8 mult field", 32'(v[MULT_W-1:0]), 32'h13);
      for (int i = 0; i < 40; i++) begin
         rd(3, v);
         if (v[26]) break;
      end
      chk("R8 lock seen", 32'(v[26]), 1);

      // R6 multiplier frozen while running
      wr(1, 32'h27);
      feed();
      chk("R6 mult frozen", 32'(pll_mult_m1), 32'h13);

      // R7 release with run
      wr(0, 32'h3);
      feed();
      chk("R7 release set", 32'(pll_release), 1);
      rd(3, v); chk("R8 release flag", 32'(v[25]), 1);

      // R5 single commit per pattern
      wr(2, 32'h55);
      wr(0, 32'h0);
      chk("R5 no second commit", 32'(pll_run), 1);
      chk("R5 release kept", 32'(pll_release), 1);
      wr(0, 32'h1);
      feed();
      chk("R5 disconnect step", 32'(pll_release), 0);
      wr(0, 32'h0);
      feed();
      chk("R5 disable step", 32'(pll_run), 0);
      feed();
      chk("R6 mult after stop", 32'(pll_mult_m1), 32'h27);

      // R9 CPU divider
      wr(4, 32'h5);
      chk("R9 ratio 6", 32'(cpu_div_ratio), 6);
      rd(4, v); chk("R9 readback", v, 32'h5);
      wr(4, 32'hFF);
      chk("R9 ratio 256", 32'(cpu_div_ratio), 256);

      // R7 run and release in one commit
      wr(0, 32'h3);
      feed();
      chk("R7 joint commit release", 32'(pll_release), 1);
      chk("R7 joint commit run", 32'(pll_run), 1);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule